// File: doc/BRIEF.md
# Programmable Strobe Pulse Timer

This block drives a single latch strobe for a serial bus master. A host loads a 7-bit width value together with a hold flag through a one-cycle write port. When the bus master raises its trigger, the strobe goes high. In long-latch mode the width value sets how long the strobe stays high, in coarse units of `UNIT_CYCLES` clock cycles. In short-latch mode the strobe stays high for a fixed `SHORT_CYCLES` clock cycles.

The width register is also the live down-counter. It loses one count for every unit of strobe time that passes, so after a long pulse has run to its end it reads zero. Writing zero to it during a long pulse cuts the pulse short. Setting the hold flag forces the strobe high until the flag is written back to zero. The strobe output is registered.

A write presents `wr_data` with `wr_en` high for one cycle. Bit 7 is the hold flag and bits 6:0 are the width.

Top module: `strobe_timer`

## Requirements
- R1: After reset the strobe is low, the width register is zero and the hold flag is clear.
- R2: In long mode (`short_mode`=0), a trigger with width W≠0 drives the strobe high from the clock edge that samples the trigger, for exactly W×UNIT_CYCLES cycles.
- R3: The width register counts down to zero over a long pulse. A second long-mode trigger after a completed pulse, with no new write, produces no strobe.
- R4: A write of width 0 during a long pulse drops the strobe at the edge that takes the write.
- R5: A long-mode trigger while the width register is zero is ignored, and the strobe stays low.
- R6: In short mode (`short_mode`=1), a trigger drives the strobe high for exactly SHORT_CYCLES cycles, whatever the width register holds, and the width register is left unchanged.
- R7: A trigger that arrives while a pulse is active is ignored, and the pulse length is unchanged.
- R8: Writing the hold flag (`wr_data[7]`=1) holds the strobe high from the next cycle on. Writing it back to 0 releases the strobe.
- R9: A write of width 0 during a short pulse does not shorten that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Bit 7 is the hold flag, bits 6:0 are the width in units |
| trig | input | 1 | Pulse request from the bus master |
| short_mode | input | 1 | 1 selects the fixed short strobe, 0 selects the programmable long strobe |
| strobe | output | 1 | Registered latch strobe |

## Verification
The assertions assume that `trig` and `wr_en` are synchronous to `clk` and only change between edges. They also assume that the width register changes in just two ways: by a write, or by the countdown of an active long pulse. Nothing else should touch it. The bench meets these assumptions by driving every input on the falling edge and sampling on the falling edge. It holds each trigger and each write for a single cycle. It lets each pulse settle fully before the next scenario starts, unless the scenario is about overlapping a running pulse on purpose.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
    localparam int WIDTH_BITS = 7;
    typedef logic [WIDTH_BITS-1:0] width_t;

    typedef struct packed {
        width_t width;
        logic   hold;
        logic   long_act;
        logic   strobe;
    } core_state_t;
endpackage

// File: rtl/unit_prescaler.sv
module unit_prescaler #(
    parameter int UNIT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run)
            cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/short_timer.sv
module short_timer #(
    parameter int SHORT_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic busy_next
);
    localparam int CW = $clog2(SHORT_CYCLES + 1);
    localparam logic [CW-1:0] LOADV = CW'(SHORT_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOADV;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
        busy      = (cnt_q != '0);
        busy_next = (cnt_d != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
    import strobe_pkg::*;
#(
    parameter int UNIT_CYCLES  = 100,
    parameter int SHORT_CYCLES = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       trig,
    input  logic       short_mode,
    output logic       strobe
);
    core_state_t st_d, st_q;
    logic tick, start_long, start_short, short_busy, short_busy_next, active;

    // Plain views of the state, also used by the bound checker.
    width_t width_q;
    logic   hold_q, long_q;
    assign width_q = st_q.width;
    assign hold_q  = st_q.hold;
    assign long_q  = st_q.long_act;

    unit_prescaler #(.UNIT_CYCLES(UNIT_CYCLES)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(start_long), .run(st_q.long_act), .tick(tick)
    );

    short_timer #(.SHORT_CYCLES(SHORT_CYCLES)) u_short (
        .clk(clk), .rst_n(rst_n), .start(start_short),
        .busy(short_busy), .busy_next(short_busy_next)
    );

    always_comb begin
        st_d        = st_q;
        active      = st_q.long_act || short_busy;
        start_short = trig && !active && short_mode;

        // A host write takes priority over the countdown.
        if (wr_en) begin
            st_d.width = wr_data[WIDTH_BITS-1:0];
            st_d.hold  = wr_data[7];
        end else if (st_q.long_act && tick) begin
            st_d.width = st_q.width - width_t'(1);
        end

        if (st_q.long_act && (st_d.width == '0))
            st_d.long_act = 1'b0;

        start_long = trig && !active && !short_mode && (st_d.width != '0);
        if (start_long)
            st_d.long_act = 1'b1;

        st_d.strobe = st_d.hold || st_d.long_act || short_busy_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.strobe;
endmodule

// File: rtl/strobe_timer_chk.sv
module strobe_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       trig,
    input logic       short_mode,
    input logic       strobe,
    input logic [6:0] width_q,
    input logic       hold_q,
    input logic       long_q,
    input logic       short_busy
);
    // R3: without a write, an active long pulse never raises the width.
    assert_width_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (long_q && !wr_en) |=> (width_q <= $past(width_q)));

    // R4: a zero width write ends a long pulse at once.
    assert_zero_write_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (long_q && wr_en && wr_data[6:0] == 7'd0) |=> (!long_q && (strobe == hold_q)));

    // R5: a long pulse only starts with a non-zero width.
    assert_long_needs_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_q) |-> (width_q != 7'd0));

    // R6: an idle short-mode trigger starts the short strobe.
    assert_short_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && short_mode && !long_q && !short_busy) |=> (short_busy && strobe));

    // R8: the hold flag forces the strobe high.
    assert_hold_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7]) |=> strobe);

    // R7: a trigger during a short pulse does not start a long one.
    assert_busy_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (short_busy && trig && !long_q) |=> !long_q);
endmodule

bind strobe_timer strobe_timer_chk u_chk (.*);

// File: tb/sim_strobe_timer.sv
`timescale 1ns/1ps
module sim_strobe_timer;
    localparam int UNIT  = 100;
    localparam int SHORT = 25;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig = 1'b0, short_mode = 1'b0;
    logic [7:0] wr_data = '0;
    logic strobe;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strobe_timer #(.UNIT_CYCLES(UNIT), .SHORT_CYCLES(SHORT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .trig(trig), .short_mode(short_mode), .strobe(strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(input logic hold, input int w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = {hold, 7'(w)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic sm);
        @(negedge clk);
        trig = 1'b1; short_mode = sm;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Counts high cycles, starting at the first negedge after the trigger edge.
    task automatic measure(output int n);
        n = 0;
        while (strobe && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1 strobe", strobe, 0);
        fire(1'b0);
        check("R1 width zero", strobe, 0);
    endtask

    task automatic t_long(input int w);
        int n;
        write(1'b0, w);
        fire(1'b0);
        measure(n);
        check("R2 long width", n, w * UNIT);
        fire(1'b0);
        check("R3 countdown to zero", strobe, 0);
    endtask

    task automatic t_abort;
        write(1'b0, 5);
        fire(1'b0);
        repeat (150) @(negedge clk);
        check("R4 running", strobe, 1);
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 aborted", strobe, 0);
    endtask

    task automatic t_zero_trig;
        write(1'b0, 0);
        fire(1'b0);
        check("R5 zero width", strobe, 0);
        repeat (3) @(negedge clk);
        check("R5 still low", strobe, 0);
    endtask

    task automatic t_short;
        int n;
        write(1'b0, 3);
        fire(1'b1);
        measure(n);
        check("R6 short width", n, SHORT);
        fire(1'b0);
        measure(n);
        check("R6 width untouched", n, 3 * UNIT);
    endtask

    task automatic t_retrig;
        int n;
        write(1'b0, 2);
        fire(1'b0);
        repeat (50) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        measure(n);
        check("R7 long retrigger", n + 51, 2 * UNIT);
        fire(1'b1);
        repeat (5) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        measure(n);
        check("R7 short retrigger", n + 6, SHORT);
    endtask

    task automatic t_hold;
        write(1'b1, 0);
        check("R8 hold on", strobe, 1);
        repeat (300) @(negedge clk);
        check("R8 hold stays", strobe, 1);
        write(1'b0, 0);
        check("R8 released", strobe, 0);
    endtask

    task automatic t_short_zero;
        int n;
        write(1'b0, 4);
        fire(1'b1);
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        measure(n);
        check("R9 short not cut", n + 5, SHORT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long(1);
        t_long(3);
        t_long(127);
        t_abort();
        t_zero_trig();
        t_short();
        t_retrig();
        t_hold();
        t_short_zero();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule